// File: doc/BRIEF.md
# I2C Clock-Line Timing Generator

This block derives the clock-line waveform of an I2C master from a fast source clock, together with two single-cycle strobes that a separate bit engine uses: one tells it when to drive the next data-line value, and one tells it when to capture the data line. Time is built in three nested stages. A prescaler divides the source clock, a sample counter groups prescaler ticks into sample units, and a phase counter counts sample units through each high and low half of the bit. With the ratio control off, each half lasts `step` sample units, so the bus frequency is source / (div × 2 × sample × step).

A high/low ratio register can set each half on its own, counted in sample units. This lets software lengthen the low phase while keeping the whole bit period, for example high = 2×step − low. A data-line timing register places the data-change strobe at a chosen sample unit inside the low phase. High-speed mode has its own timing and ratio registers. It takes effect only when the mode input asks for it and the high-speed timing register carries its enable code.

The controller has three states. In IDLE the clock line is high and all counters are clear. IDLE→HIGH is taken when `en` is sampled high. HIGH→LOW and LOW→HIGH are taken when the phase counter completes the length of the current half. HIGH→IDLE and LOW→IDLE are taken whenever `en` is sampled low.

Top module: `scl_timing_gen`

## Requirements
- R1: While `en` is low the block is in IDLE: `scl_o` is 1 and neither strobe pulses. From the cycle after `en` is sampled low, `scl_o` is 1.
- R2: In base mode with the ratio off, each high and each low phase lasts step × sample × div source cycles. The fields are: `base_timing[10:8]` = sample−1, `base_timing[5:0]` = step−1, `clk_div_m1` = div−1.
- R3: When bit 12 of the selected ratio register is set, the high phase lasts `[11:6]` sample units and the low phase lasts `[5:0]` sample units. A field of zero is taken as one sample unit.
- R4: When `hs_sel` is 1 and `hs_timing[1:0]` is 2'b11, the block uses the high-speed values: sample−1 from `hs_timing[14:12]`, step−1 from `hs_timing[10:8]`, and the ratio from `hs_ratio`.
- R5: When `hs_sel` is 1 but `hs_timing[1:0]` is not 2'b11, the block uses the base timing and the base ratio.
- R6: `sda_upd_o` pulses exactly once in each low phase, in the last cycle of sample unit P, counting from 0 at the start of the phase. When `sda_timing[12]` is set, P is `sda_timing[5:0]` in base mode and `sda_timing[11:6]` in high-speed mode, clamped to low−1. When `sda_timing[12]` is clear, P is floor(low/2).
- R7: `scl_smp_o` pulses exactly once in each high phase, in the last cycle of the phase's first sample unit.
- R8: `sda_upd_o` is asserted only while `scl_o` is 0, and `scl_smp_o` only while `scl_o` is 1.
- R9: When `en` goes low and then high again, the first high phase after re-enable has its full length, because every counter restarts from zero.
- R10: The prescaler supports the full divide range up to 256 (`clk_div_m1` = 255).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Run enable; low holds the clock line high and clears the counters |
| hs_sel | input | 1 | Requests high-speed timing |
| clk_div_m1 | input | 8 | Prescaler divide minus one |
| base_timing | input | 16 | Base sample and step counts, each minus one |
| hs_timing | input | 16 | High-speed sample and step counts plus the enable code |
| base_ratio | input | 16 | Base high/low phase lengths with their enable |
| hs_ratio | input | 16 | High-speed high/low phase lengths with their enable |
| sda_timing | input | 16 | Data-change point in the low phase, with its enable |
| scl_o | output | 1 | Clock-line level |
| sda_upd_o | output | 1 | Data-change strobe |
| scl_smp_o | output | 1 | Data-capture strobe |

## Verification
The bound checker watches the following on every cycle:
- the clock line returns high after `en` drops;
- each strobe occurs only in its own half of the bit;
- each completed low phase carries exactly one data-change strobe;
- each completed high phase carries exactly one capture strobe.

The cycle counts need the directed scenarios, which measure them at the ports. These counts are the lengths of each half, the exact position of each strobe, the clamping of an out-of-range change point, the zero-length fields, the choice between high-speed and base values, the full 256 divide, and the full-length restart.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } scl_state_t;

    // base timing register fields
    localparam int BT_STEP_LSB = 0;
    localparam int BT_SMP_LSB  = 8;
    // high-speed timing register fields
    localparam int HT_EN_LSB   = 0;
    localparam int HT_STEP_LSB = 8;
    localparam int HT_SMP_LSB  = 12;
    localparam logic [1:0] HT_EN_CODE = 2'b11;
    // ratio register fields
    localparam int RT_EN_BIT   = 12;
    localparam int RT_HI_LSB   = 6;
    localparam int RT_LO_LSB   = 0;
    // data-change point register fields
    localparam int SD_EN_BIT   = 12;
    localparam int SD_BASE_LSB = 0;
    localparam int SD_HS_LSB   = 6;

endpackage

// File: rtl/scl_tg_stage.sv
module scl_tg_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic         wrap
);
    logic [W-1:0] cnt;

    assign wrap = inc && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_tg_decode.sv
module scl_tg_decode
    import scl_tg_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int SMP_W     = 3,
    parameter int STEP_W    = 6,
    parameter int HS_STEP_W = 3,
    parameter int CNT_W     = STEP_W + 1
) (
    input  logic             hs_sel,
    input  logic [REG_W-1:0] base_timing,
    input  logic [REG_W-1:0] hs_timing,
    input  logic [REG_W-1:0] base_ratio,
    input  logic [REG_W-1:0] hs_ratio,
    input  logic [REG_W-1:0] sda_timing,
    output logic [SMP_W-1:0] sample_m1,
    output logic [CNT_W-1:0] high_len,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] sda_pt
);
    logic             hs_on;
    logic [CNT_W-1:0] step_len;
    logic [REG_W-1:0] ratio;
    logic [CNT_W-1:0] rat_hi, rat_lo, pt_raw;
    logic             unused_bits;

    assign unused_bits = ^{base_timing, hs_timing, base_ratio, hs_ratio, sda_timing};

    assign hs_on = hs_sel && (hs_timing[HT_EN_LSB +: 2] == HT_EN_CODE);

    always_comb begin
        if (hs_on) begin
            sample_m1 = hs_timing[HT_SMP_LSB +: SMP_W];
            step_len  = CNT_W'(hs_timing[HT_STEP_LSB +: HS_STEP_W]) + CNT_W'(1);
            ratio     = hs_ratio;
            pt_raw    = CNT_W'(sda_timing[SD_HS_LSB +: STEP_W]);
        end else begin
            sample_m1 = base_timing[BT_SMP_LSB +: SMP_W];
            step_len  = CNT_W'(base_timing[BT_STEP_LSB +: STEP_W]) + CNT_W'(1);
            ratio     = base_ratio;
            pt_raw    = CNT_W'(sda_timing[SD_BASE_LSB +: STEP_W]);
        end

        rat_hi = CNT_W'(ratio[RT_HI_LSB +: STEP_W]);
        rat_lo = CNT_W'(ratio[RT_LO_LSB +: STEP_W]);

        if (ratio[RT_EN_BIT]) begin
            high_len = (rat_hi == '0) ? CNT_W'(1) : rat_hi;
            low_len  = (rat_lo == '0) ? CNT_W'(1) : rat_lo;
        end else begin
            high_len = step_len;
            low_len  = step_len;
        end

        if (sda_timing[SD_EN_BIT]) begin
            sda_pt = (pt_raw >= low_len) ? (low_len - CNT_W'(1)) : pt_raw;
        end else begin
            sda_pt = low_len >> 1;
        end
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int DIV_W     = 8,
    parameter int SMP_W     = 3,
    parameter int STEP_W    = 6,
    parameter int HS_STEP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hs_sel,
    input  logic [DIV_W-1:0] clk_div_m1,
    input  logic [REG_W-1:0] base_timing,
    input  logic [REG_W-1:0] hs_timing,
    input  logic [REG_W-1:0] base_ratio,
    input  logic [REG_W-1:0] hs_ratio,
    input  logic [REG_W-1:0] sda_timing,
    output logic             scl_o,
    output logic             sda_upd_o,
    output logic             scl_smp_o
);
    localparam int CNT_W = STEP_W + 1;

    scl_state_t       state, nxt;
    logic             run, div_tick, samp_tick, phase_end;
    logic [SMP_W-1:0] sample_m1;
    logic [CNT_W-1:0] high_len, low_len, sda_pt, cur_len_m1, ph_cnt;

    scl_tg_decode #(
        .REG_W(REG_W), .SMP_W(SMP_W), .STEP_W(STEP_W),
        .HS_STEP_W(HS_STEP_W), .CNT_W(CNT_W)
    ) i_decode (
        .hs_sel     (hs_sel),
        .base_timing(base_timing),
        .hs_timing  (hs_timing),
        .base_ratio (base_ratio),
        .hs_ratio   (hs_ratio),
        .sda_timing (sda_timing),
        .sample_m1  (sample_m1),
        .high_len   (high_len),
        .low_len    (low_len),
        .sda_pt     (sda_pt)
    );

    assign run = en && (state != ST_IDLE);

    scl_tg_stage #(.W(DIV_W)) i_prescale (
        .clk(clk), .rst_n(rst_n), .clr(!run), .inc(run),
        .lim(clk_div_m1), .wrap(div_tick)
    );

    scl_tg_stage #(.W(SMP_W)) i_sample (
        .clk(clk), .rst_n(rst_n), .clr(!run), .inc(div_tick),
        .lim(sample_m1), .wrap(samp_tick)
    );

    assign cur_len_m1 = ((state == ST_LOW) ? low_len : high_len) - CNT_W'(1);
    assign phase_end  = samp_tick && (ph_cnt == cur_len_m1);

    // phase (step) counter: sample units elapsed in the current half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt <= '0;
        end else if (!run || phase_end) begin
            ph_cnt <= '0;
        end else if (samp_tick) begin
            ph_cnt <= ph_cnt + CNT_W'(1);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (en) nxt = ST_HIGH;
            ST_HIGH: begin
                if (!en)            nxt = ST_IDLE;
                else if (phase_end) nxt = ST_LOW;
            end
            ST_LOW: begin
                if (!en)            nxt = ST_IDLE;
                else if (phase_end) nxt = ST_HIGH;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        scl_o     = (state != ST_LOW);
        scl_smp_o = (state == ST_HIGH) && samp_tick && (ph_cnt == '0);
        sda_upd_o = (state == ST_LOW) && samp_tick && (ph_cnt == sda_pt);
    end
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_o,
    input logic sda_upd_o,
    input logic scl_smp_o
);
    logic [1:0] upd_cnt, smp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_cnt <= '0;
            smp_cnt <= '0;
        end else begin
            if (scl_o || !en)              upd_cnt <= '0;
            else if (sda_upd_o && upd_cnt != 2'd3) upd_cnt <= upd_cnt + 2'd1;
            if (!scl_o || !en)             smp_cnt <= '0;
            else if (scl_smp_o && smp_cnt != 2'd3) smp_cnt <= smp_cnt + 2'd1;
        end
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> scl_o);

    assert_upd_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_upd_o |-> !scl_o);

    assert_smp_in_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_smp_o |-> scl_o);

    assert_one_upd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_o) && $past(en) && en) |-> (upd_cnt == 2'd1));

    assert_one_smp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_o) && $past(en) && en) |-> (smp_cnt == 2'd1));
endmodule

bind scl_timing_gen scl_timing_gen_chk i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .scl_o(scl_o),
    .sda_upd_o(sda_upd_o), .scl_smp_o(scl_smp_o)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        hs_sel = 1'b0;
    logic [7:0]  clk_div_m1 = '0;
    logic [15:0] base_timing = '0, hs_timing = '0, base_ratio = '0;
    logic [15:0] hs_ratio = '0, sda_timing = '0;
    logic        scl_o, sda_upd_o, scl_smp_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_timing_gen i_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .hs_sel(hs_sel),
        .clk_div_m1(clk_div_m1), .base_timing(base_timing),
        .hs_timing(hs_timing), .base_ratio(base_ratio),
        .hs_ratio(hs_ratio), .sda_timing(sda_timing),
        .scl_o(scl_o), .sda_upd_o(sda_upd_o), .scl_smp_o(scl_smp_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input logic [7:0] dv, input logic [15:0] bt, input logic [15:0] ht,
                         input logic [15:0] br, input logic [15:0] hr, input logic [15:0] st,
                         input logic hs);
        @(negedge clk);
        en = 1'b0;
        clk_div_m1 = dv; base_timing = bt; hs_timing = ht;
        base_ratio = br; hs_ratio = hr; sda_timing = st; hs_sel = hs;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    // measures one full low phase then the following high phase
    task automatic measure(input int ehi, input int elo, input int eupd, input int esmp,
                           input string req);
        int lo = 0, hi = 0, upd_at = -1, smp_at = -1, guard = 0;
        @(negedge clk);
        while (scl_o && guard < 5000) begin @(negedge clk); guard++; end
        while (!scl_o && guard < 5000) begin
            if (sda_upd_o) upd_at = lo;
            lo++; guard++; @(negedge clk);
        end
        while (scl_o && guard < 5000) begin
            if (scl_smp_o) smp_at = hi;
            hi++; guard++; @(negedge clk);
        end
        check(lo == elo, {req, " low length"}, lo, elo);
        check(hi == ehi, {req, " high length"}, hi, ehi);
        check(upd_at == eupd, {req, " data-change position"}, upd_at, eupd);
        check(smp_at == esmp, {req, " capture position"}, smp_at, esmp);
    endtask

    task automatic t_reset_idle;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(scl_o == 1'b1 && !sda_upd_o && !scl_smp_o, "R1 idle outputs",
                  {scl_o, sda_upd_o, scl_smp_o}, 3'b100);
        end
    endtask

    task automatic t_base;   // R2 R6 R7: div 2, sample 3, step 4
        start(8'd1, 16'h0203, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        measure(24, 24, 17, 5, "R2");
    endtask

    task automatic t_ratio;  // R3 R6: sample 2, high 5, low 3, point 1
        start(8'd0, 16'h0100, 16'h0, 16'h1000 | (16'd5 << 6) | 16'd3, 16'h0,
              16'h1000 | 16'd1, 1'b0);
        measure(10, 6, 3, 1, "R3");
    endtask

    task automatic t_clamp;  // R6: point 10 clamped to low-1 = 2
        start(8'd0, 16'h0100, 16'h0, 16'h1000 | (16'd5 << 6) | 16'd3, 16'h0,
              16'h1000 | 16'd10, 1'b0);
        measure(10, 6, 5, 1, "R6 clamp");
    endtask

    task automatic t_zero;   // R3: zero fields count as one unit
        start(8'd0, 16'h0100, 16'h0, 16'h1000, 16'h0, 16'h1000, 1'b0);
        measure(2, 2, 1, 1, "R3 zero fields");
    endtask

    task automatic t_hs;     // R4: hs sample 2 step 3, point 1 from [11:6]
        start(8'd0, 16'h0007, 16'h1203, 16'h0, 16'h0,
              16'h1000 | (16'd1 << 6), 1'b1);
        measure(6, 6, 3, 1, "R4");
    endtask

    task automatic t_hs_off; // R5: enable code absent, base sample 1 step 5
        start(8'd0, 16'h0004, 16'h1200, 16'h0, 16'h1000 | 16'd1, 16'h0, 1'b1);
        measure(5, 5, 2, 0, "R5");
    endtask

    task automatic t_restart; // R1 R9
        int hi = 0;
        start(8'd1, 16'h0203, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        @(negedge clk);
        while (scl_o) @(negedge clk);
        repeat (5) @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(scl_o == 1'b1 && !sda_upd_o && !scl_smp_o, "R1 disabled mid-low",
                  {scl_o, sda_upd_o, scl_smp_o}, 3'b100);
        end
        en = 1'b1;
        @(negedge clk);
        while (scl_o && hi < 5000) begin hi++; @(negedge clk); end
        check(hi == 24, "R9 first high after restart", hi, 24);
    endtask

    task automatic t_div_max; // R10
        start(8'd255, 16'h0000, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        measure(256, 256, 255, 255, "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_base();
        t_ratio();
        t_clamp();
        t_zero();
        t_hs();
        t_hs_off();
        t_restart();
        t_div_max();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule